// File: doc/BRIEF.md
# Exception catch event evaluator

This block runs once after every exception entry or exit. It decides whether that transition should stop the processor for debug and, if so, raises a halt request carrying the exception-catch reason code. Software or a debugger loads a 16-bit catch-control word through a simple write port. After each transition, the exception machinery pulses a strobe. With the strobe it presents the exception level and security state of the target (the state after the transition) and a flag that tells entry from exit. A separate input says whether halting is currently allowed.

The control word has one slot for each exception level in each security state. The slot index is the level plus 4 in the non-secure state, or plus 0 in the secure state. In legacy mode only the low bit of the slot matters: when it is set, the block halts on both entry and exit. In extended mode a second bit, 8 positions above the first, forms a 2-bit control with it. That control selects never, always, exit only or entry only.

A parameter marks which levels are implemented. Slots belonging to an absent level always read as 0. The decision is made by a two-state machine. ST_IDLE moves to ST_HALT on a catching strobe. ST_HALT stays in ST_HALT on another catching strobe and otherwise returns to ST_IDLE. ST_IDLE stays in ST_IDLE without a catching strobe. The request is high only in ST_HALT.

Top module: `exc_catch_eval`

## Requirements
- R1: After reset halt_req is 0, halt_reason is 000000 and the stored control word is all zero, so no strobe can cause a halt until the word is written.
- R2: In legacy mode (ext_mode=0), a strobe causes a halt exactly when control bit {nonsecure, cur_el} (bit index = level + 4 when non-secure) is 1, on either entry or exit; bits 8 to 15 have no effect.
- R3: In extended mode (ext_mode=1), the control is {bit 8+{nonsecure,cur_el}, bit {nonsecure,cur_el}}: 00 never halts, 01 halts on entry and exit, 10 halts only on exit (evt_is_entry=0), 11 halts only on entry (evt_is_entry=1).
- R4: When halt_allowed is 0 in the strobe cycle, no halt request is produced.
- R5: The halt request is registered: it is high in the cycle right after a catching strobe, for one cycle per strobe, and never without a strobe in the previous cycle.
- R6: While halt_req is 1, halt_reason is 110111; while it is 0, halt_reason is 000000.
- R7: Control bits whose level is absent in LEVEL_MAP (default: level 2 absent) are stored as 0 and never cause a halt.
- R8: A control write in the same cycle as a strobe does not affect that strobe; the new value governs strobes from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 16 | Control word write data |
| ext_mode | input | 1 | 1 selects extended 2-bit control |
| cur_el | input | 2 | Exception level of the target |
| nonsecure | input | 1 | 1 when the target is non-secure |
| evt_valid | input | 1 | Entry/exit strobe |
| evt_is_entry | input | 1 | 1 for entry, 0 for exit |
| halt_allowed | input | 1 | Halting currently allowed |
| halt_req | output | 1 | One-cycle exception-catch halt request |
| halt_reason | output | 6 | Reason code, 110111 with the request |

## Verification
Every strobe is answered exactly one cycle later: the request and its reason code appear after the clock edge that samples the strobe and fall after the next edge unless another catching strobe came in. The bench applies inputs just after a falling edge and compares the outputs at the next falling edge, one rising edge later, against a model that uses the control word as it stood before any write made in the strobe cycle. A write takes effect at the same rising edge, so the model updates its copy only after the comparison.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    localparam int LVL_W     = 2;
    localparam int NUM_LVL   = 1 << LVL_W;
    localparam int SLOT_W    = LVL_W + 1;
    localparam int HALF_W    = 1 << SLOT_W;
    localparam int CTRL_W    = 2 * HALF_W;
    localparam int REASON_W  = 6;
    localparam logic [REASON_W-1:0] REASON_EXC_CATCH = 6'b110111;

    typedef enum logic [1:0] {
        CC_NEVER  = 2'b00,
        CC_ALWAYS = 2'b01,
        CC_EXIT   = 2'b10,
        CC_ENTRY  = 2'b11
    } catch_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HALT = 1'b1
    } catch_state_e;
endpackage

// File: rtl/ecc_ctrl_reg.sv
module ecc_ctrl_reg
    import ecc_pkg::*;
#(
    parameter logic [NUM_LVL-1:0] LEVEL_MAP = 4'b1011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q
);
    logic [CTRL_W-1:0] keep_mask;

    for (genvar i = 0; i < CTRL_W; i++) begin : g_mask
        assign keep_mask[i] = LEVEL_MAP[i % NUM_LVL];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we) begin
            ctrl_q <= wdata & keep_mask;
        end
    end
endmodule

// File: rtl/ecc_decide.sv
module ecc_decide
    import ecc_pkg::*;
(
    input  logic              [CTRL_W-1:0] ctrl,
    input  logic                           ext_mode,
    input  logic              [LVL_W-1:0]  cur_el,
    input  logic                           nonsecure,
    input  logic                           evt_is_entry,
    output logic                           hit
);
    logic [SLOT_W-1:0] slot;
    logic [HALF_W-1:0] lo_half;
    logic [HALF_W-1:0] hi_half;
    catch_mode_e       mode;

    assign slot    = {nonsecure, cur_el};
    assign lo_half = ctrl[HALF_W-1:0];
    assign hi_half = ctrl[CTRL_W-1:HALF_W];
    assign mode    = catch_mode_e'({hi_half[slot], lo_half[slot]});

    always_comb begin
        if (!ext_mode) begin
            hit = lo_half[slot];
        end else begin
            unique case (mode)
                CC_NEVER:  hit = 1'b0;
                CC_ALWAYS: hit = 1'b1;
                CC_EXIT:   hit = !evt_is_entry;
                CC_ENTRY:  hit = evt_is_entry;
                default:   hit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/ecc_fsm.sv
module ecc_fsm
    import ecc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire,
    output logic                halt_req,
    output logic [REASON_W-1:0] halt_reason
);
    catch_state_e state_q;
    catch_state_e state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = fire ? ST_HALT : ST_IDLE;
            ST_HALT: state_d = fire ? ST_HALT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_HALT: begin
                halt_req    = 1'b1;
                halt_reason = REASON_EXC_CATCH;
            end
            default: begin
                halt_req    = 1'b0;
                halt_reason = '0;
            end
        endcase
    end
endmodule

// File: rtl/exc_catch_eval.sv
module exc_catch_eval
    import ecc_pkg::*;
#(
    parameter logic [NUM_LVL-1:0] LEVEL_MAP = 4'b1011
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CTRL_W-1:0]   cfg_wdata,
    input  logic                ext_mode,
    input  logic [LVL_W-1:0]    cur_el,
    input  logic                nonsecure,
    input  logic                evt_valid,
    input  logic                evt_is_entry,
    input  logic                halt_allowed,
    output logic                halt_req,
    output logic [REASON_W-1:0] halt_reason
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              catch_hit;
    logic              fire;

    ecc_ctrl_reg #(.LEVEL_MAP(LEVEL_MAP)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .ctrl_q (ctrl_q)
    );

    ecc_decide u_dec (
        .ctrl         (ctrl_q),
        .ext_mode     (ext_mode),
        .cur_el       (cur_el),
        .nonsecure    (nonsecure),
        .evt_is_entry (evt_is_entry),
        .hit          (catch_hit)
    );

    assign fire = evt_valid && halt_allowed && catch_hit;

    ecc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (fire),
        .halt_req    (halt_req),
        .halt_reason (halt_reason)
    );
endmodule

// File: rtl/ecc_checker.sv
module ecc_checker
    import ecc_pkg::*;
#(
    parameter logic [NUM_LVL-1:0] LEVEL_MAP = 4'b1011
) (
    input logic                clk,
    input logic                rst_n,
    input logic                evt_valid,
    input logic                halt_allowed,
    input logic [LVL_W-1:0]    cur_el,
    input logic                halt_req,
    input logic [REASON_W-1:0] halt_reason
);
    a_r5_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |=> !halt_req);

    a_r4_needs_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !halt_allowed) |=> !halt_req);

    a_r7_absent_level: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !LEVEL_MAP[cur_el]) |=> !halt_req);

    a_r6_reason_on: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> (halt_reason == 6'b110111));

    a_r6_reason_off: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_req |-> (halt_reason == 6'b000000));

    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> !halt_req);
endmodule

bind exc_catch_eval ecc_checker #(.LEVEL_MAP(LEVEL_MAP)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_valid    (evt_valid),
    .halt_allowed (halt_allowed),
    .cur_el       (cur_el),
    .halt_req     (halt_req),
    .halt_reason  (halt_reason)
);

// File: tb/test_exc_catch_eval.sv
`timescale 1ns/1ps
module test_exc_catch_eval;
    localparam logic [3:0] LMAP = 4'b1011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        ext_mode = 1'b0;
    logic [1:0]  cur_el = '0;
    logic        nonsecure = 1'b0;
    logic        evt_valid = 1'b0;
    logic        evt_is_entry = 1'b0;
    logic        halt_allowed = 1'b0;
    logic        halt_req;
    logic [5:0]  halt_reason;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] shadow = '0;

    always #4 clk = ~clk;

    exc_catch_eval #(.LEVEL_MAP(LMAP)) i_exc_catch_eval (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ext_mode(ext_mode), .cur_el(cur_el), .nonsecure(nonsecure),
        .evt_valid(evt_valid), .evt_is_entry(evt_is_entry),
        .halt_allowed(halt_allowed), .halt_req(halt_req), .halt_reason(halt_reason)
    );

    function automatic logic model(logic [15:0] c, logic ext, logic [1:0] el,
                                   logic ns, logic v, logic ent, logic al);
        int s;
        logic lo, hi;
        s  = {29'd0, ns, el};
        lo = c[s] & LMAP[el];
        hi = c[s+8] & LMAP[el];
        if (!v || !al) return 1'b0;
        if (!ext) return lo;
        case ({hi, lo})
            2'b00: return 1'b0;
            2'b01: return 1'b1;
            2'b10: return !ent;
            default: return ent;
        endcase
    endfunction

    function automatic logic [15:0] masked(logic [15:0] w);
        logic [15:0] m;
        for (int i = 0; i < 16; i++) m[i] = w[i] & LMAP[i % 4];
        return m;
    endfunction

    task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(string tag, logic we, logic [15:0] wd, logic ext,
                        logic [1:0] el, logic ns, logic v, logic ent, logic al);
        logic e;
        cfg_we = we; cfg_wdata = wd; ext_mode = ext; cur_el = el;
        nonsecure = ns; evt_valid = v; evt_is_entry = ent; halt_allowed = al;
        e = model(shadow, ext, el, ns, v, ent, al);
        @(posedge clk);
        @(negedge clk);
        check(tag, {5'd0, halt_req}, {5'd0, e});
        check({tag, " reason R6"}, halt_reason, e ? 6'b110111 : 6'b000000);
        if (we) shadow = masked(wd);
    endtask

    task automatic wr(logic [15:0] w);
        step("write idle", 1'b1, w, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset req", {5'd0, halt_req}, 6'd0);
        check("R1 reset reason", halt_reason, 6'd0);
        rst_n = 1'b1;
        // R1: control resets to zero
        for (int l = 0; l < 4; l++) begin
            step("R1 no halt from cleared ctrl", 0, '0, 0, 2'(l), 1'b1, 1, 1, 1);
            step("R1 no halt from cleared ctrl ext", 0, '0, 1, 2'(l), 1'b0, 1, 0, 1);
        end
        // R2: legacy, non-secure EL1 = bit 5, high bits ignored
        wr(16'h0020);
        step("R2 legacy entry", 0, '0, 0, 2'd1, 1, 1, 1, 1);
        step("R2 legacy exit", 0, '0, 0, 2'd1, 1, 1, 0, 1);
        step("R2 secure EL1 bit1 clear", 0, '0, 0, 2'd1, 0, 1, 1, 1);
        step("R5 idle after request", 0, '0, 0, 2'd1, 1, 0, 1, 1);
        wr(16'hFF00);
        step("R2 legacy high bits ignored", 0, '0, 0, 2'd3, 1, 1, 1, 1);
        // R3: extended modes at secure EL3 (bits 3 and 11)
        wr(16'h0008);
        step("R3 code01 entry", 0, '0, 1, 2'd3, 0, 1, 1, 1);
        step("R3 code01 exit", 0, '0, 1, 2'd3, 0, 1, 0, 1);
        wr(16'h0800);
        step("R3 code10 entry", 0, '0, 1, 2'd3, 0, 1, 1, 1);
        step("R3 code10 exit", 0, '0, 1, 2'd3, 0, 1, 0, 1);
        wr(16'h0808);
        step("R3 code11 entry", 0, '0, 1, 2'd3, 0, 1, 1, 1);
        step("R3 code11 exit", 0, '0, 1, 2'd3, 0, 1, 0, 1);
        step("R2 legacy sees low bit only", 0, '0, 0, 2'd3, 0, 1, 0, 1);
        // R4
        step("R4 not allowed", 0, '0, 1, 2'd3, 0, 1, 1, 0);
        // R5: back-to-back strobes
        step("R5 back to back a", 0, '0, 1, 2'd3, 0, 1, 1, 1);
        step("R5 back to back b", 0, '0, 1, 2'd3, 0, 1, 1, 1);
        step("R5 drop", 0, '0, 1, 2'd3, 0, 0, 1, 1);
        // R7: level 2 absent
        wr(16'hFFFF);
        step("R7 absent secure EL2", 0, '0, 0, 2'd2, 0, 1, 1, 1);
        step("R7 absent nonsecure EL2 ext", 0, '0, 1, 2'd2, 1, 1, 0, 1);
        step("R7 present EL0", 0, '0, 0, 2'd0, 1, 1, 0, 1);
        // R8: same-cycle write uses old value
        wr(16'h0000);
        step("R8 write with strobe uses old", 1, 16'h0001, 0, 2'd0, 0, 1, 1, 1);
        step("R8 new value next cycle", 0, '0, 0, 2'd0, 0, 1, 1, 1);
        step("R8 clear with strobe uses old", 1, 16'h0000, 0, 2'd0, 0, 1, 1, 1);
        step("R8 cleared next cycle", 0, '0, 0, 2'd0, 0, 1, 1, 1);
        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r;
            r = $urandom;
            step("R2 R3 R4 R5 R7 R8 random", r[0] & r[1], 16'($urandom), r[2],
                 r[4:3], r[5], r[6] | r[7], r[8], r[9] | r[10]);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule